// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shutdown

This block supervises software by counting slow timebase ticks and demanding a periodic kick. An 8-bit control register holds an enable bit, a shutdown-unlock bit and a 3-bit period select. While the watchdog is enabled, a counter advances on every cycle where the tick-enable input is high. A kick restarts the count from zero. If the count reaches the selected limit first, the block raises a one-cycle reset request for the device.

The tick-enable input stands in for a separate slow oscillator. All logic runs on the bus clock. The eight periods double at each step, starting from `2**BASE_LOG2` ticks. With the default setting this gives 16K up to 2048K ticks.

Turning the watchdog off is guarded. Software must first write the unlock bit and the enable bit together as ones. That opens a window of four bus cycles. A write that clears enable inside that window turns the watchdog off. A write that clears enable outside the window is ignored. The unlock bit clears itself when the window closes.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `reset_req` is low. The watchdog is disabled and period select is 0.
- R2: Bits 7..5 of `rd_data` always read zero, even after a write of ones to them.
- R3: The register layout is: bit 4 is unlock, bit 3 is enable, bits 2..0 are period select. A write with bits 4 and 3 both one sets unlock. Unlock reads 1 in the four cycles after that write and reads 0 from the fifth cycle on. A write with bit 4 set and bit 3 clear does not set unlock.
- R4: A write with bit 3 clear turns the watchdog off when it lands within four cycles after the unlocking write. The fourth cycle is the last one that works.
- R5: A write with bit 3 clear leaves the watchdog enabled if no window is open. This includes a write made five or more cycles after the unlocking write.
- R6: When enabled with period select s, `reset_req` pulses high for exactly one cycle. It fires on the cycle after the count reaches `2**(BASE_LOG2+s)` ticks. The count is measured from the enable, the last kick or the last timeout, and it restarts at zero after the timeout.
- R7: The count advances only on cycles where `tick` is high.
- R8: A `kick` sets the count back to zero.
- R9: If a `kick` arrives on the same cycle a timeout would fire, no reset request is issued.
- R10: While the watchdog is disabled, the count stays at zero and no reset request appears. After re-enabling, a full period is needed before a timeout.
- R11: Every write updates period select. If the running count already meets the new, smaller limit, the reset request fires on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Watchdog timebase enable, one pulse per slow-oscillator tick |
| kick | input | 1 | Software kick; restarts the timeout count |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| reset_req | output | 1 | One-cycle device reset request on timeout |

## Verification
The bench hits the unlock window at both edges: a clearing write four cycles after the unlock and one five cycles after. A design with an off-by-one window either lets the late write disable the watchdog or refuses the last legal one. A kick is placed on the exact timeout cycle, and the bench checks that no reset request appears. A wrong priority would reset the device even though software was alive. The bench also shrinks the period select while the count is above the new limit. A design that only compares for equality would then miss the timeout and keep counting. Reserved-bit readback, tick gating and re-enable from a zero count are checked against a cycle-accurate model kept in the bench.

// File: rtl/wdt_pkg.sv
// Shared types for the watchdog block.
// Assumes the 8-bit control layout: [4] unlock, [3] enable, [2:0] period select.
package wdt_pkg;

    localparam int SEL_W   = 3;
    localparam int NUM_SEL = 1 << SEL_W;
    localparam int BIT_UNL = 4;
    localparam int BIT_EN  = 3;

    typedef struct packed {
        logic             unlock;
        logic             enable;
        logic [SEL_W-1:0] sel;
    } wdt_ctrl_t;

endpackage

// File: rtl/wdt_unlock_window.sv
// Unlock window timer: raises win_open for WINDOW cycles after arm.
// A re-arm during an open window restarts the full window.
// Assumes WINDOW >= 2.
module wdt_unlock_window #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic win_open
);
    localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam logic [CW-1:0] LOAD = CW'(WINDOW - 1);

    logic [CW-1:0] remain;

    // Load on arm, count down while open, close after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b0;
            remain   <= '0;
        end else if (arm) begin
            win_open <= 1'b1;
            remain   <= LOAD;
        end else if (win_open) begin
            if (remain == '0) begin
                win_open <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_ctrl_reg.sv
// Control register with guarded enable clear.
// Enable is set by any write with the enable bit one. It is cleared only by a
// write with the enable bit zero while the unlock window is open. Period
// select takes every write. Assumes wr_bits is already stripped of reserved bits.
module wdt_ctrl_reg
    import wdt_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [4:0] wr_bits,
    output wdt_ctrl_t  ctrl
);
    logic arm;
    logic win_open;
    logic en_q;
    logic [SEL_W-1:0] sel_q;

    // Combined write of unlock and enable opens the window.
    always_comb arm = wr_en && wr_bits[BIT_UNL] && wr_bits[BIT_EN];

    wdt_unlock_window #(.WINDOW(WINDOW)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .win_open (win_open)
    );

    // Enable and period-select state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (wr_en) begin
            sel_q <= wr_bits[SEL_W-1:0];
            if (wr_bits[BIT_EN]) begin
                en_q <= 1'b1;
            end else if (win_open) begin
                en_q <= 1'b0;
            end
        end
    end

    // Pack the visible register fields.
    always_comb begin
        ctrl.unlock = win_open;
        ctrl.enable = en_q;
        ctrl.sel    = sel_q;
    end
endmodule

// File: rtl/wdt_timeout_core.sv
// Timeout counter: counts ticks while enabled and compares against the limit
// picked by sel. The limit is 2**(BASE_LOG2+sel), one comparator per choice.
// A kick clears the count and takes priority over a timeout.
// Assumes the count is held at zero while disabled.
module wdt_timeout_core
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    input  logic             tick,
    input  logic             kick,
    output logic             reset_req
);
    localparam int CW = BASE_LOG2 + NUM_SEL;

    logic [CW-1:0]      count;
    logic [NUM_SEL-1:0] reached;
    logic               fire;

    // One threshold comparator per period choice.
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_limit
        localparam logic [CW-1:0] LIMIT = CW'(1) << (BASE_LOG2 + i);
        assign reached[i] = (count >= LIMIT);
    end

    // Timeout decision; a kick wins over a timeout.
    always_comb fire = enable && reached[sel] && !kick;

    // Count update and registered reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= fire;
            if (!enable || kick || fire) begin
                count <= '0;
            end else if (tick) begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_guard.sv
// Top of the watchdog: control register plus timeout core.
// Reserved bits 7..5 read as zero and ignore writes.
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int WINDOW    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       kick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       reset_req
);
    wdt_ctrl_t ctrl;
    logic      unused_rsvd;

    // Reserved write bits are dropped.
    assign unused_rsvd = ^wr_data[7:5];

    wdt_ctrl_reg #(.WINDOW(WINDOW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits (wr_data[4:0]),
        .ctrl    (ctrl)
    );

    wdt_timeout_core #(.BASE_LOG2(BASE_LOG2)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ctrl.enable),
        .sel       (ctrl.sel),
        .tick      (tick),
        .kick      (kick),
        .reset_req (reset_req)
    );

    // Read view of the control register.
    assign rd_data = {3'b000, ctrl.unlock, ctrl.enable, ctrl.sel};
endmodule

// File: rtl/wdt_guard_checker.sv
// Port-level properties of the watchdog, bound to wdt_guard.
// Assumes WINDOW = 4 for the unlock-age limit.
module wdt_guard_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       kick,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       reset_req
);
    logic [3:0] unl_age;

    // Cycles since the unlocking write, saturating while unlock stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unl_age <= '0;
        end else if (wr_en && wr_data[4] && wr_data[3]) begin
            unl_age <= '0;
        end else if (rd_data[4] && unl_age != 4'hF) begin
            unl_age <= unl_age + 1'b1;
        end
    end

    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:5] == 3'b000);

    a_r3_unlock_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> unl_age <= 4'd3);

    a_r5_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3] && !rd_data[4]) |=> rd_data[3]);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    a_r9_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !reset_req);

    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[3] |=> !reset_req);
endmodule

bind wdt_guard wdt_guard_checker u_wdt_guard_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick      (kick),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .reset_req (reset_req)
);

// File: tb/tb_wdt_guard.sv
// Scoreboard bench: the driver pushes the expected per-cycle outputs,
// and the monitor pops and compares them after each clock edge.
module tb_wdt_guard;
    localparam int CLK_PERIOD = 10;
    localparam int BASE_LOG2  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       kick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       reset_req;

    typedef struct {
        logic       req;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;

    // Reference state built from the requirements.
    logic       m_en = 0, m_unl = 0;
    int         m_left = 0, m_cnt = 0;
    logic [2:0] m_sel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guard #(.BASE_LOG2(BASE_LOG2), .WINDOW(4)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .reset_req(reset_req)
    );

    function automatic int lim(input logic [2:0] s);
        return (1 << BASE_LOG2) << s;
    endfunction

    task automatic step(input logic w, input logic [7:0] d, input logic t,
                        input logic k, input string tag);
        logic fire;
        exp_t e;
        @(negedge clk);
        wr_en = w; wr_data = d; tick = t; kick = k;
        fire = m_en && (m_cnt >= lim(m_sel)) && !k;
        if (!m_en || k || fire) m_cnt = 0;
        else if (t) m_cnt = m_cnt + 1;
        if (w) begin
            if (d[3]) m_en = 1'b1;
            else if (m_unl) m_en = 1'b0;
        end
        if (w && d[4] && d[3]) begin
            m_unl = 1'b1; m_left = 3;
        end else if (m_unl) begin
            if (m_left == 0) m_unl = 1'b0;
            else m_left = m_left - 1;
        end
        if (w) m_sel = d[2:0];
        e.req = fire;
        e.rd  = {3'b000, m_unl, m_en, m_sel};
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 8'h00, 1, 0, tag);
    endtask

    task automatic wr(input logic [7:0] d, input string tag);
        step(1, d, 0, 0, tag);
    endtask

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare outputs one time unit after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(reset_req === e.req, e.tag, "reset_req", int'(reset_req), int'(e.req));
            check(rd_data === e.rd, e.tag, "rd_data", int'(rd_data), int'(e.rd));
        end
    end

    // Watchdog for a hung run.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(rd_data === 8'h00, "R1", "rd_data in reset", int'(rd_data), 0);
        check(reset_req === 1'b0, "R1", "reset_req in reset", int'(reset_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3, "R1");

        // R2: reserved bits ignored; enable with select 3
        wr(8'hEB, "R2");
        idle(2, "R2");
        // R11 write updates select; back to 0 (limit 16)
        wr(8'h08, "R11");
        // R6: timeout after 16 ticks, then restart
        ticks(40, "R6");
        // R7: gapped ticks
        for (int i = 0; i < 20; i++) begin
            step(0, 8'h00, 1, 0, "R7");
            step(0, 8'h00, 0, 0, "R7");
        end
        // R8: kick restarts count
        step(0, 8'h00, 0, 1, "R8");
        ticks(10, "R8");
        step(0, 8'h00, 1, 1, "R8");
        ticks(15, "R8");
        // R9: kick exactly on the timeout cycle
        ticks(1, "R9");
        step(0, 8'h00, 1, 1, "R9");
        idle(2, "R9");
        // R11: larger limit, then shrink below count
        wr(8'h0A, "R11");
        ticks(40, "R11");
        wr(8'h08, "R11");
        idle(3, "R11");
        // R5: clear enable without unlock
        wr(8'h00, "R5");
        idle(2, "R5");
        // R3: unlock bit alone does not open window
        wr(8'h10, "R3");
        wr(8'h00, "R3");
        // R5: clear five cycles after unlock fails
        wr(8'h18, "R5");
        idle(4, "R5");
        wr(8'h00, "R5");
        idle(2, "R5");
        // R4: clear on fourth cycle after unlock succeeds
        wr(8'h18, "R4");
        idle(3, "R4");
        wr(8'h00, "R4");
        // R10: disabled, ticks have no effect
        ticks(60, "R10");
        wr(8'h08, "R10");
        ticks(20, "R10");
        // R6: longest period
        wr(8'h0F, "R6");
        ticks(2060, "R6");
        // R4: clear on first cycle after unlock
        wr(8'h18, "R4");
        wr(8'h00, "R4");
        ticks(5, "R4");
        idle(3, "R1");
        @(posedge clk); #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule